// File: doc/BRIEF.md
# Row/Column Strobed DRAM Sequencer with Burst Reads and Refresh

This block turns single processor-side requests into the strobe sequence that a DRAM with shared row/column address pins expects. A request carries a flat address, a direction and, for writes, one data word. The controller splits the address, puts the row part on the pins with the row strobe, and waits a programmable row-to-column delay. It then puts the column part on the same pins with a one-cycle column strobe. A write completes in that column cycle. A read gets back a burst of four consecutive words, in which the device advances its own column counter. The controller issues no more column strobes and marks each returned word with a one-cycle valid pulse.

An interval timer runs all the time beside the access path. Each time it expires, one row refresh becomes pending. A pending refresh takes the pins at the next idle cycle, ahead of any waiting request. A refresh is a row-strobe-only operation that lasts a fixed number of clocks and addresses the row held in a refresh counter. That counter steps by one after every refresh. All outputs to the device come straight from registers.

Top module: `dram_burst_ctrl`

## Requirements
- R1: The row part of a request is `req_addr[20:9]`, driven on `mem_a` while the row strobe is high. The column part is `req_addr[8:0]`, driven zero-extended on `mem_a` in the column-strobe cycle.
- R2: `mem_cs` and `mem_row_stb` go high in the cycle after the accepting clock edge. `mem_col_stb` is high for exactly one cycle, T_RCD cycles after the row strobe rose. The row strobe stays high through that cycle.
- R3: A read issues exactly one column strobe. `rd_valid` then pulses on four consecutive cycles, the first of them T_CL+1 cycles after the column-strobe cycle. Beat i carries the word that the device drove on `mem_din` T_CL+i cycles after the column strobe, which is the device's column col+i modulo 512.
- R4: In a write's column-strobe cycle, `mem_wr` and `mem_doe` are high and `mem_dout` carries the request's data. The row strobe falls on the next cycle, so the operation lasts T_RCD+1 cycles.
- R5: With no traffic, a refresh starts exactly every REF_INTERVAL clocks. A refresh holds `mem_row_stb` and `mem_cs` high for REF_CYCLES cycles with no column strobe and `mem_wr` low. `mem_a` carries a refresh row that starts at 0 after reset and rises by one per refresh. Under traffic, consecutive refresh starts are never more than REF_INTERVAL plus one read operation apart.
- R6: `req_ready` is high only when no operation is running and no refresh is pending. When a refresh is pending and a request is waiting, the refresh goes first. Every row-strobe operation that follows an accepting edge is that request's access.
- R7: `mem_cs` and `mem_wr` do not change while the row strobe is high. A read keeps the row strobe up through its last beat, so it lasts T_RCD+T_CL+4 cycles. Between two operations there is at least one cycle with every strobe and chip select low.
- R8: While reset is held and right after it, `req_ready` is high and `mem_cs`, both strobes, `mem_doe` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write one word, 0 = burst read |
| req_addr | input | 21 | Flat word address (row in 20:9, column in 8:0) |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request taken on this edge when high with req_valid |
| rd_data | output | 16 | Read burst word |
| rd_valid | output | 1 | One-cycle pulse per burst word |
| mem_cs | output | 1 | Device chip select (active high) |
| mem_row_stb | output | 1 | Row strobe (active high) |
| mem_col_stb | output | 1 | Column strobe (active high) |
| mem_wr | output | 1 | Write direction to device |
| mem_a | output | 12 | Shared row/column address pins |
| mem_dout | output | 16 | Write data to device |
| mem_doe | output | 1 | Write data drive enable |
| mem_din | input | 16 | Read data from device |

## Verification
The two functions that can fall into the same cycle are expiry of the refresh timer and acceptance of a processor request. The bench keeps a request waiting almost continuously, so that the timer often expires while an access is in flight or while the controller is idle. It then judges each row-strobe operation by whether it was preceded by an accepting edge: an operation that follows an accepting edge must carry a column strobe, and one that does not follow such an edge must be a refresh. The bench also bounds the spacing between refreshes. A quiet phase with no requests checks that the refresh spacing equals the interval exactly.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_RCD,
    ST_COL,
    ST_LAT
  } ctrl_state_e;

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);

  // upper field selects the row, lower field the column
  assign row = addr[ADDR_W-1:COL_W];
  assign col = addr[COL_W-1:0];

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 1562,
  parameter int ROW_W    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             pend,
  output logic [ROW_W-1:0] row
);

  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(INTERVAL - 1));

  // free-running: spacing does not depend on when the refresh was served
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
      row  <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (tick)     pend <= 1'b1;
      else if (ack) pend <= 1'b0;
      if (ack)      row  <= row + ROW_W'(1);
    end
  end

  p_ack_needs_pend_r6: assert property (@(posedge clk) disable iff (rst)
    ack |-> pend);

  p_pend_drops_r5: assert property (@(posedge clk) disable iff (rst)
    (ack && !tick) |=> !pend);

  p_row_steps_r5: assert property (@(posedge clk) disable iff (rst)
    ack |=> (row == $past(row) + ROW_W'(1)));

endmodule

// File: rtl/dram_burst_capture.sv
module dram_burst_capture #(
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int T_CL      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              last
);

  localparam int BW = $clog2(BURST_LEN + 1);

  logic [T_CL-1:0] dly;
  logic [BW-1:0]   left;
  logic            start;
  logic            window;

  // latency line from the column strobe to the first data beat
  generate
    if (T_CL == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (rst) dly <= '0;
        else     dly <= launch;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (rst) dly <= '0;
        else     dly <= {dly[T_CL-2:0], launch};
      end
    end
  endgenerate

  assign start  = dly[T_CL-1];
  assign window = start || (left != '0);
  assign last   = window && (start ? (BURST_LEN == 1) : (left == BW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      left     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= window;
      if (window) rd_data <= din;
      if (start)            left <= BW'(BURST_LEN - 1);
      else if (left != '0)  left <= left - BW'(1);
    end
  end

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    launch |-> (left == '0 && !start));

  p_last_ends_r3: assert property (@(posedge clk) disable iff (rst)
    (last && !launch) |=> (left == '0));

endmodule

// File: rtl/dram_ctrl_fsm.sv
module dram_ctrl_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 9,
  parameter int DATA_W     = 16,
  parameter int T_RCD      = 2,
  parameter int REF_CYCLES = 4,
  localparam int PIN_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              ref_pend,
  input  logic [ROW_W-1:0]  ref_row,
  output logic              ref_ack,
  output logic              launch,
  input  logic              burst_last,
  output logic              mem_cs,
  output logic              mem_row_stb,
  output logic              mem_col_stb,
  output logic              mem_wr,
  output logic [PIN_W-1:0]  mem_a,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe
);

  localparam int MAXC = (T_RCD > REF_CYCLES) ? T_RCD : REF_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  ctrl_state_e       state;
  logic [CW-1:0]     cnt;
  logic [COL_W-1:0]  col_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_ready = (state == ST_IDLE) && !ref_pend;
  assign ref_ack   = (state == ST_IDLE) && ref_pend;
  assign launch    = (state == ST_COL) && !wr_q;

  // outputs are loaded with the values of the state being entered
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      col_q       <= '0;
      wr_q        <= 1'b0;
      wdata_q     <= '0;
      mem_cs      <= 1'b0;
      mem_row_stb <= 1'b0;
      mem_col_stb <= 1'b0;
      mem_wr      <= 1'b0;
      mem_a       <= '0;
      mem_dout    <= '0;
      mem_doe     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            state       <= ST_REF;
            cnt         <= '0;
            mem_cs      <= 1'b1;
            mem_row_stb <= 1'b1;
            mem_wr      <= 1'b0;
            mem_a       <= PIN_W'(ref_row);
          end else if (req_valid) begin
            state       <= ST_RCD;
            cnt         <= '0;
            col_q       <= req_col;
            wr_q        <= req_write;
            wdata_q     <= req_wdata;
            mem_cs      <= 1'b1;
            mem_row_stb <= 1'b1;
            mem_wr      <= req_write;
            mem_a       <= PIN_W'(req_row);
          end
        end
        ST_REF: begin
          if (cnt == CW'(REF_CYCLES - 1)) begin
            state       <= ST_IDLE;
            mem_cs      <= 1'b0;
            mem_row_stb <= 1'b0;
            mem_a       <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_RCD: begin
          if (cnt == CW'(T_RCD - 1)) begin
            state       <= ST_COL;
            mem_col_stb <= 1'b1;
            mem_a       <= PIN_W'(col_q);
            mem_doe     <= wr_q;
            if (wr_q) mem_dout <= wdata_q;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_COL: begin
          mem_col_stb <= 1'b0;
          mem_doe     <= 1'b0;
          if (wr_q) begin
            state       <= ST_IDLE;
            mem_cs      <= 1'b0;
            mem_row_stb <= 1'b0;
            mem_wr      <= 1'b0;
            mem_a       <= '0;
          end else begin
            state <= ST_LAT;
          end
        end
        ST_LAT: begin
          if (burst_last) begin
            state       <= ST_IDLE;
            mem_cs      <= 1'b0;
            mem_row_stb <= 1'b0;
            mem_wr      <= 1'b0;
            mem_a       <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_col_in_row_r2: assert property (@(posedge clk) disable iff (rst)
    mem_col_stb |-> (mem_row_stb && mem_cs));

  p_single_col_r3: assert property (@(posedge clk) disable iff (rst)
    mem_col_stb |=> !mem_col_stb);

  p_hold_ctl_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_row_stb && $past(mem_row_stb)) |-> ($stable(mem_cs) && $stable(mem_wr)));

  p_gap_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_row_stb) |-> (!mem_cs && !mem_col_stb && !mem_doe));

  p_ready_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_row_stb && !mem_col_stb));

endmodule

// File: rtl/dram_burst_ctrl.sv
module dram_burst_ctrl #(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 16,
  parameter int BURST_LEN    = 4,
  parameter int T_RCD        = 2,
  parameter int T_CL         = 2,
  parameter int REF_CYCLES   = 4,
  parameter int REF_INTERVAL = 1562,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              mem_cs,
  output logic              mem_row_stb,
  output logic              mem_col_stb,
  output logic              mem_wr,
  output logic [PIN_W-1:0]  mem_a,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din
);

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             ref_pend;
  logic             ref_ack;
  logic [ROW_W-1:0] ref_row;
  logic             launch;
  logic             burst_last;

  dram_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr (req_addr),
    .row  (req_row),
    .col  (req_col)
  );

  dram_refresh_timer #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .ack  (ref_ack),
    .pend (ref_pend),
    .row  (ref_row)
  );

  dram_ctrl_fsm #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .REF_CYCLES(REF_CYCLES)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_row     (req_row),
    .req_col     (req_col),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .ref_pend    (ref_pend),
    .ref_row     (ref_row),
    .ref_ack     (ref_ack),
    .launch      (launch),
    .burst_last  (burst_last),
    .mem_cs      (mem_cs),
    .mem_row_stb (mem_row_stb),
    .mem_col_stb (mem_col_stb),
    .mem_wr      (mem_wr),
    .mem_a       (mem_a),
    .mem_dout    (mem_dout),
    .mem_doe     (mem_doe)
  );

  dram_burst_capture #(
    .DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .T_CL(T_CL)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .din      (mem_din),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .last     (burst_last)
  );

  p_valid_only_in_read_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (mem_row_stb || $past(mem_row_stb)));

endmodule

// File: tb/sim_dram_burst_ctrl.sv
module sim_dram_burst_ctrl;

  localparam int ROW_W = 12, COL_W = 9, DATA_W = 16, BURST = 4;
  localparam int T_RCD = 2, T_CL = 2, REF_CYC = 4, REF_INT = 1562;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int READ_LEN = T_RCD + T_CL + BURST;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_cs, mem_row_stb, mem_col_stb, mem_wr, mem_doe;
  logic [DATA_W-1:0] rd_data, mem_dout;
  logic [DATA_W-1:0] mem_din = '0;
  logic [ROW_W-1:0] mem_a;

  dram_burst_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_cs(mem_cs),
    .mem_row_stb(mem_row_stb), .mem_col_stb(mem_col_stb), .mem_wr(mem_wr),
    .mem_a(mem_a), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device contents: written words, otherwise a computed pattern
  logic [DATA_W-1:0] store [logic [ADDR_W-1:0]];

  function automatic logic [DATA_W-1:0] dev_word(logic [ROW_W-1:0] r, logic [COL_W-1:0] c);
    logic [ADDR_W-1:0] k;
    k = {r, c};
    if (store.exists(k)) return store[k];
    return DATA_W'(r * 37 + c * 5 + 16'h1234) ^ 16'h0f0f;
  endfunction

  typedef struct { bit wr; logic [ADDR_W-1:0] addr; logic [DATA_W-1:0] data; } req_t;
  req_t pend_q[$];
  req_t cur;

  // monitor and device model, evaluated mid-cycle
  longint cyc = 0;
  bit acc_last = 0, op_is_req = 0, prev_row = 0, prev_cs = 0, stab_bad = 0, ready_bad = 0;
  bit quiet_phase = 1, bact = 0;
  longint op_start = 0, col_cyc = 0, bstart = 0, last_ref = -1;
  int col_n = 0, nb = 0, n_ref = 0, quiet_spacings = 0;
  bit op_cs = 0, op_wr = 0;
  logic [ROW_W-1:0] op_row = '0, brow = '0;
  logic [COL_W-1:0] bcol = '0;
  logic [ROW_W-1:0] exp_ref = '0;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0;
    end else begin
      cyc++;
      if (bact && cyc >= bstart && cyc < bstart + BURST)
        mem_din = dev_word(brow, COL_W'(bcol + COL_W'(cyc - bstart)));
      else
        mem_din = 16'hdead;
      if (req_ready && (mem_row_stb || mem_col_stb)) ready_bad = 1;
      if (rd_valid) begin
        chk(cyc == bstart + 1 + nb, "R3", "beat cycle", cyc, bstart + 1 + nb);
        chk(rd_data == dev_word(brow, COL_W'(bcol + COL_W'(nb))), "R3", "beat data",
            rd_data, dev_word(brow, COL_W'(bcol + COL_W'(nb))));
        nb++;
      end
      if (mem_row_stb && !prev_row) begin
        chk(!prev_cs, "R7", "quiet cycle before op", prev_cs, 0);
        op_start = cyc; op_row = mem_a; op_cs = mem_cs; op_wr = mem_wr;
        col_n = 0; stab_bad = 0; op_is_req = acc_last;
        if (op_is_req) begin
          cur = pend_q.pop_front();
          chk(mem_a == cur.addr[ADDR_W-1:COL_W], "R1", "row on pins", mem_a, cur.addr[ADDR_W-1:COL_W]);
          chk(mem_cs && mem_wr == cur.wr, "R2", "cs and direction at row strobe", {mem_cs, mem_wr}, {1'b1, cur.wr});
        end
      end
      if (mem_row_stb && (mem_cs != op_cs || mem_wr != op_wr)) stab_bad = 1;
      if (mem_col_stb) begin
        col_n++;
        chk(cyc - op_start == T_RCD, "R2", "row-to-column delay", cyc - op_start, T_RCD);
        if (op_is_req) chk(mem_a == ROW_W'(cur.addr[COL_W-1:0]), "R1", "column on pins", mem_a, cur.addr[COL_W-1:0]);
        if (mem_wr) begin
          chk(mem_doe && mem_dout == cur.data, "R4", "write data", {mem_doe, mem_dout}, {1'b1, cur.data});
          store[{op_row, mem_a[COL_W-1:0]}] = mem_dout;
        end else begin
          bact = 1; bstart = cyc + T_CL; brow = op_row; bcol = mem_a[COL_W-1:0]; nb = 0; col_cyc = cyc;
        end
      end
      if (!mem_row_stb && prev_row) begin
        chk((col_n > 0) == op_is_req, "R6", "op kind after accept edge", col_n > 0, op_is_req);
        chk(!stab_bad, "R7", "cs/wr steady under row strobe", stab_bad, 0);
        if (col_n == 0) begin
          chk(cyc - op_start == REF_CYC, "R5", "refresh length", cyc - op_start, REF_CYC);
          chk(op_row == exp_ref && !op_wr, "R5", "refresh row", op_row, exp_ref);
          exp_ref++;
          n_ref++;
          if (last_ref >= 0) begin
            if (quiet_phase) begin
              chk(op_start - last_ref == REF_INT, "R5", "quiet refresh spacing", op_start - last_ref, REF_INT);
              quiet_spacings++;
            end else begin
              chk(op_start - last_ref <= REF_INT + READ_LEN + 1, "R5", "busy refresh spacing",
                  op_start - last_ref, REF_INT + READ_LEN + 1);
            end
          end
          last_ref = op_start;
        end else if (op_wr) begin
          chk(col_n == 1 && cyc - op_start == T_RCD + 1, "R4", "write length", cyc - op_start, T_RCD + 1);
        end else begin
          chk(col_n == 1, "R3", "single column strobe", col_n, 1);
          chk(nb == BURST, "R3", "beat count", nb, BURST);
          chk(cyc - op_start == READ_LEN, "R7", "read holds row to last beat", cyc - op_start, READ_LEN);
          bact = 0;
        end
      end
      acc_last = req_valid && req_ready;
      if (acc_last) pend_q.push_back('{req_write, req_addr, req_wdata});
      prev_row = mem_row_stb;
      prev_cs = mem_cs;
    end
  end

  task automatic do_req(bit wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (pend_q.size() != 0 || mem_row_stb || rd_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  logic [ADDR_W-1:0] wlist[$];

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8: state under reset
    chk(req_ready && !mem_cs && !mem_row_stb && !mem_col_stb && !mem_doe && !rd_valid,
        "R8", "outputs in reset", {req_ready, mem_cs, mem_row_stb, mem_col_stb, mem_doe, rd_valid}, 6'b100000);
    @(posedge clk); #2 rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_row_stb && !rd_valid, "R8", "outputs after reset", {req_ready, mem_row_stb, rd_valid}, 3'b100);

    // quiet phase: exact refresh spacing (R5)
    repeat (3 * REF_INT + 40) @(negedge clk);
    chk(quiet_spacings >= 2, "R5", "quiet refreshes seen", quiet_spacings, 2);
    quiet_phase = 0;

    // directed corners
    do_req(1'b0, {12'h000, 9'd0}, '0);         drain();
    do_req(1'b0, {12'hfff, 9'd511}, '0);       drain();  // column wraps inside device (R3)
    do_req(1'b1, {12'hfff, 9'd511}, 16'hbeef); drain();
    do_req(1'b1, {12'hfff, 9'd0}, 16'h0ace);   drain();
    do_req(1'b0, {12'hfff, 9'd510}, '0);       drain();  // reads back both writes across the wrap
    do_req(1'b1, {12'h5a5, 9'd128}, 16'h1357); drain();
    do_req(1'b0, {12'h5a5, 9'd127}, '0);       drain();

    // random traffic, requests held back-to-back to collide with refresh (R6)
    for (int i = 0; i < 1400; i++) begin
      bit wr;
      logic [ADDR_W-1:0] a;
      wr = ($urandom % 3) == 0;
      if (!wr && wlist.size() != 0 && ($urandom % 2)) a = wlist[$urandom % wlist.size()];
      else a = ADDR_W'($urandom);
      if (wr) begin
        wlist.push_back(a);
        if (wlist.size() > 32) void'(wlist.pop_front());
      end
      do_req(wr, a, DATA_W'($urandom));
    end
    drain();

    chk(!ready_bad, "R6", "ready only when quiet", ready_bad, 0);
    chk(n_ref >= int'(cyc / REF_INT) - 1, "R5", "refresh count", n_ref, cyc / REF_INT - 1);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=done", 200000);
    summary();
  end

endmodule